// File: doc/BRIEF.md
# DMA Channel Pending and Active Flag Tracker

This block keeps two flags for each of sixteen DMA channels. The pending flag records that a channel has been requested and is waiting for service. The active flag records that the channel currently sits in the controller's execution queue. Both flag sets are presented as read-only 32-bit words: bit n belongs to channel n, and the upper half always reads zero.

A request is accepted when a hardware trigger arrives on a channel whose hardware enable is set, or when a software trigger arrives on a channel whose software enable is set. Once set, a pending flag ignores any later change to the enables. It is removed only by one of these events on its own channel:
- a completion that matches the channel's transfer type (end of frame for frame-type channels, end of block for block-type channels);
- a rewrite of the channel's control packet;
- a bus error.

The active flag follows queue entry and exit events only. The global enable and the emulation flag do not affect it.

The completion, packet-write, bus-error and queue events arrive as single-cycle pulses, each carrying a 4-bit channel index. Both words are held in registers, so a change made in one cycle becomes readable on the next.

Top module: `dma_chan_tracker`

## Requirements
- R1: Bit n of `pend_word` and of `active_word` belongs to channel n, for n from 0 to 15. Bits 31..16 of both words always read 0. The block has no write path into either word.
- R2: The pending bit of channel n is set when `hw_req[n]`=1 and `hw_req_en[n]`=1, or when `sw_req[n]`=1 and `sw_req_en[n]`=1. A trigger whose matching enable is 0 leaves the bit unchanged.
- R3: A set pending bit stays set when `hw_req_en[n]` or `sw_req_en[n]` is later cleared. A trigger on a bit that is already set has no further effect. The bit clears only through R4, R5 or R6.
- R4: `xfer_is_block[n]`=0 selects frame type and 1 selects block type. A `frame_end` pulse with `frame_end_ch`=n clears pending bit n only when the channel is frame type. A `block_end` pulse with `block_end_ch`=n clears it only when the channel is block type.
- R5: A `pkt_write` pulse with `pkt_write_ch`=n clears pending bit n.
- R6: A `bus_fault` pulse with `bus_fault_ch`=n clears pending bit n.
- R7: When a clear event (R4, R5 or R6) and an accepted trigger hit the same channel in the same cycle, the pending bit ends at 0.
- R8: A `q_enter` pulse with `q_enter_ch`=n sets active bit n. A `q_leave` pulse with `q_leave_ch`=n clears it. When both name the same channel in the same cycle, the bit ends at 0.
- R9: `dma_global_en` and `emu_active` have no effect on the active bits: a queued channel stays at 1 while either input changes.
- R10: A synchronous active-high `rst` clears both words to 0.
- R11: An event presented in a cycle becomes visible on the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 16 | Hardware trigger strobes, one per channel |
| sw_req | input | 16 | Software trigger strobes, one per channel |
| hw_req_en | input | 16 | Hardware trigger enable mask |
| sw_req_en | input | 16 | Software trigger enable mask |
| xfer_is_block | input | 16 | Transfer type per channel: 1 = block, 0 = frame |
| frame_end | input | 1 | End-of-frame pulse |
| frame_end_ch | input | 4 | Channel of the end-of-frame pulse |
| block_end | input | 1 | End-of-block pulse |
| block_end_ch | input | 4 | Channel of the end-of-block pulse |
| pkt_write | input | 1 | Control-packet write pulse |
| pkt_write_ch | input | 4 | Channel whose packet is written |
| bus_fault | input | 1 | Bus error pulse |
| bus_fault_ch | input | 4 | Channel of the bus error |
| q_enter | input | 1 | Execution-queue entry event |
| q_enter_ch | input | 4 | Channel entering the queue |
| q_leave | input | 1 | Execution-queue exit event |
| q_leave_ch | input | 4 | Channel leaving the queue |
| dma_global_en | input | 1 | Global DMA enable (does not affect the flags) |
| emu_active | input | 1 | Emulation mode flag (does not affect the flags) |
| pend_word | output | 32 | Pending flags, zero-extended |
| active_word | output | 32 | Active (queued) flags, zero-extended |

## Verification
Two pairs of events can land on the same channel in one cycle.
- A trigger and a clear can collide. The bench provokes this directly, with a software trigger and a packet write on one channel, and also through random traffic in which trigger vectors and clear indices overlap often. The pending bit must end at 0.
- A queue entry and a queue exit can collide. The bench names the same channel for both, and the active bit must end at 0.

The expected words come from a bench model that applies the set first and then the clears. They are compared on the falling edge after each update.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int DCT_NCH  = 16;
  localparam int DCT_REGW = 32;
endpackage

// File: rtl/dct_onehot.sv
module dct_onehot #(
  parameter int NCH  = 16,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            vld,
  input  logic [IDXW-1:0] idx,
  output logic [NCH-1:0]  oh
);
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      oh[i] = vld && (idx == IDXW'(i));
    end
  end
endmodule

// File: rtl/dct_pend_track.sv
module dct_pend_track #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] sw_req,
  input  logic [NCH-1:0] hw_req_en,
  input  logic [NCH-1:0] sw_req_en,
  input  logic [NCH-1:0] xfer_is_block,
  input  logic [NCH-1:0] frame_oh,
  input  logic [NCH-1:0] block_oh,
  input  logic [NCH-1:0] pkt_oh,
  input  logic [NCH-1:0] fault_oh,
  output logic [NCH-1:0] pend_q
);
  logic [NCH-1:0] accept;
  logic [NCH-1:0] retire;

  always_comb begin
    accept = (hw_req & hw_req_en) | (sw_req & sw_req_en);
    retire = (frame_oh & ~xfer_is_block) | (block_oh & xfer_is_block)
           | pkt_oh | fault_oh;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q | accept) & ~retire;
  end
endmodule

// File: rtl/dct_queue_track.sv
module dct_queue_track #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] enter_oh,
  input  logic [NCH-1:0] leave_oh,
  output logic [NCH-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else     active_q <= (active_q | enter_oh) & ~leave_oh;
  end
endmodule

// File: rtl/dma_chan_tracker.sv
module dma_chan_tracker #(
  parameter int NCH  = dct_pkg::DCT_NCH,
  parameter int REGW = dct_pkg::DCT_REGW,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  hw_req,
  input  logic [NCH-1:0]  sw_req,
  input  logic [NCH-1:0]  hw_req_en,
  input  logic [NCH-1:0]  sw_req_en,
  input  logic [NCH-1:0]  xfer_is_block,
  input  logic            frame_end,
  input  logic [IDXW-1:0] frame_end_ch,
  input  logic            block_end,
  input  logic [IDXW-1:0] block_end_ch,
  input  logic            pkt_write,
  input  logic [IDXW-1:0] pkt_write_ch,
  input  logic            bus_fault,
  input  logic [IDXW-1:0] bus_fault_ch,
  input  logic            q_enter,
  input  logic [IDXW-1:0] q_enter_ch,
  input  logic            q_leave,
  input  logic [IDXW-1:0] q_leave_ch,
  input  logic            dma_global_en,
  input  logic            emu_active,
  output logic [REGW-1:0] pend_word,
  output logic [REGW-1:0] active_word
);
  localparam int PADW = REGW - NCH;

  logic [NCH-1:0] frame_oh, block_oh, pkt_oh, fault_oh, enter_oh, leave_oh;
  logic [NCH-1:0] pend_q, active_q;

  dct_onehot #(.NCH(NCH), .IDXW(IDXW)) u_dec_frame (.vld(frame_end), .idx(frame_end_ch), .oh(frame_oh));
  dct_onehot #(.NCH(NCH), .IDXW(IDXW)) u_dec_block (.vld(block_end), .idx(block_end_ch), .oh(block_oh));
  dct_onehot #(.NCH(NCH), .IDXW(IDXW)) u_dec_pkt   (.vld(pkt_write), .idx(pkt_write_ch), .oh(pkt_oh));
  dct_onehot #(.NCH(NCH), .IDXW(IDXW)) u_dec_fault (.vld(bus_fault), .idx(bus_fault_ch), .oh(fault_oh));
  dct_onehot #(.NCH(NCH), .IDXW(IDXW)) u_dec_enter (.vld(q_enter),   .idx(q_enter_ch),   .oh(enter_oh));
  dct_onehot #(.NCH(NCH), .IDXW(IDXW)) u_dec_leave (.vld(q_leave),   .idx(q_leave_ch),   .oh(leave_oh));

  dct_pend_track #(.NCH(NCH)) u_pend (
    .clk(clk), .rst(rst),
    .hw_req(hw_req), .sw_req(sw_req),
    .hw_req_en(hw_req_en), .sw_req_en(sw_req_en),
    .xfer_is_block(xfer_is_block),
    .frame_oh(frame_oh), .block_oh(block_oh),
    .pkt_oh(pkt_oh), .fault_oh(fault_oh),
    .pend_q(pend_q)
  );

  // Queue residency is tracked from queue events alone; dma_global_en and
  // emu_active are deliberately not part of this path (R9).
  dct_queue_track #(.NCH(NCH)) u_queue (
    .clk(clk), .rst(rst),
    .enter_oh(enter_oh), .leave_oh(leave_oh),
    .active_q(active_q)
  );

  generate
    if (PADW > 0) begin : g_pad
      assign pend_word   = {{PADW{1'b0}}, pend_q};
      assign active_word = {{PADW{1'b0}}, active_q};
    end else begin : g_nopad
      assign pend_word   = pend_q[REGW-1:0];
      assign active_word = active_q[REGW-1:0];
    end
  endgenerate
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int NCH  = 16,
  parameter int REGW = 32,
  parameter int IDXW = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst,
  input logic [NCH-1:0]  hw_req,
  input logic [NCH-1:0]  sw_req,
  input logic            frame_end,
  input logic            block_end,
  input logic            pkt_write,
  input logic [IDXW-1:0] pkt_write_ch,
  input logic            bus_fault,
  input logic [IDXW-1:0] bus_fault_ch,
  input logic            q_enter,
  input logic [IDXW-1:0] q_enter_ch,
  input logic            q_leave,
  input logic [IDXW-1:0] q_leave_ch,
  input logic            dma_global_en,
  input logic            emu_active,
  input logic [REGW-1:0] pend_word,
  input logic [REGW-1:0] active_word
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (pend_word[REGW-1:NCH] == '0) && (active_word[REGW-1:NCH] == '0));

  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (rst)
    (hw_req == '0 && sw_req == '0) |=> ((pend_word & ~$past(pend_word)) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!frame_end && !block_end && !pkt_write && !bus_fault)
      |=> ((pend_word & $past(pend_word)) == $past(pend_word)));

  p_pkt_clear_r5: assert property (@(posedge clk) disable iff (rst)
    pkt_write |=> !pend_word[$past(pkt_write_ch)]);

  p_fault_clear_r6: assert property (@(posedge clk) disable iff (rst)
    bus_fault |=> !pend_word[$past(bus_fault_ch)]);

  p_enter_r8: assert property (@(posedge clk) disable iff (rst)
    (q_enter && !(q_leave && q_leave_ch == q_enter_ch)) |=> active_word[$past(q_enter_ch)]);

  p_leave_r8: assert property (@(posedge clk) disable iff (rst)
    q_leave |=> !active_word[$past(q_leave_ch)]);

  p_mode_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (!q_enter && !q_leave && ($changed(dma_global_en) || $changed(emu_active)))
      |=> $stable(active_word));

  p_quiet_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!q_enter && !q_leave) |=> $stable(active_word));
endmodule

bind dma_chan_tracker dct_checker #(.NCH(NCH), .REGW(REGW), .IDXW(IDXW)) u_chk (.*);

// File: tb/tb_dma_chan_tracker.sv
module tb_dma_chan_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] hw_req, sw_req, hw_req_en, sw_req_en, xfer_is_block;
  logic frame_end, block_end, pkt_write, bus_fault, q_enter, q_leave;
  logic [3:0] frame_end_ch, block_end_ch, pkt_write_ch, bus_fault_ch, q_enter_ch, q_leave_ch;
  logic dma_global_en, emu_active;
  logic [31:0] pend_word, active_word;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] pm = '0, am = '0;

  always #5 clk = ~clk;

  dma_chan_tracker dut (.*);

  function automatic logic [15:0] oh(input logic v, input logic [3:0] i);
    return v ? (16'h1 << i) : 16'h0;
  endfunction

  function automatic logic [15:0] pend_next(input logic [15:0] p);
    logic [15:0] acc, clr;
    acc = (hw_req & hw_req_en) | (sw_req & sw_req_en);
    clr = (oh(frame_end, frame_end_ch) & ~xfer_is_block)
        | (oh(block_end, block_end_ch) & xfer_is_block)
        | oh(pkt_write, pkt_write_ch) | oh(bus_fault, bus_fault_ch);
    return (p | acc) & ~clr;
  endfunction

  function automatic logic [15:0] act_next(input logic [15:0] a);
    return (a | oh(q_enter, q_enter_ch)) & ~oh(q_leave, q_leave_ch);
  endfunction

  task automatic idle();
    hw_req = '0; sw_req = '0;
    frame_end = 0; block_end = 0; pkt_write = 0; bus_fault = 0;
    q_enter = 0; q_leave = 0;
    frame_end_ch = 0; block_end_ch = 0; pkt_write_ch = 0; bus_fault_ch = 0;
    q_enter_ch = 0; q_leave_ch = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: model update at the edge, compare at the following falling edge.
  task automatic step(input string req);
    @(posedge clk);
    if (rst) begin pm = '0; am = '0; end
    else begin pm = pend_next(pm); am = act_next(am); end
    @(negedge clk);
    check({req, " pend"},   pend_word,   {16'h0, pm});
    check({req, " active"}, active_word, {16'h0, am});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    idle();
    hw_req_en = '0; sw_req_en = '0; xfer_is_block = '0;
    dma_global_en = 1; emu_active = 0;
    rst = 1;
    @(negedge clk);
    step("R10 reset"); step("R10 reset");
    rst = 0;
    check("R10 pend after reset", pend_word, 32'h0);
    check("R10 active after reset", active_word, 32'h0);

    // R2: trigger without its enable is ignored
    hw_req = 16'h0008; sw_req_en = 16'h0008;
    step("R2 hw trig, hw enable off");
    idle();
    check("R2 no set without enable", pend_word, 32'h0);
    // R2 + R11: software trigger with enable; not visible before the edge
    sw_req = 16'h0008;
    #1 check("R11 not yet visible", pend_word, 32'h0);
    step("R2 sw trig");
    idle();
    check("R2 bit3 set", pend_word, 32'h0000_0008);

    // R3: enables dropped, bit persists; repeated trigger no effect
    sw_req_en = '0; hw_req_en = '0;
    step("R3 enable cleared");
    check("R3 persists", pend_word, 32'h0000_0008);

    // R4: block-type channel ignores frame end, clears on block end
    xfer_is_block = 16'h0008;
    frame_end = 1; frame_end_ch = 3;
    step("R4 frame end on block type");
    idle();
    check("R4 not cleared by frame end", pend_word, 32'h0000_0008);
    block_end = 1; block_end_ch = 3;
    step("R4 block end");
    idle();
    check("R4 cleared by block end", pend_word, 32'h0);

    // R7: trigger and packet write in the same cycle, clear wins
    sw_req_en = 16'h0020; sw_req = 16'h0020; pkt_write = 1; pkt_write_ch = 5;
    step("R7 trigger plus clear");
    idle();
    check("R7 clear wins", pend_word, 32'h0);
    // R5: packet write after the bit is set
    sw_req = 16'h0020; step("R5 set"); idle();
    pkt_write = 1; pkt_write_ch = 5; step("R5 pkt write"); idle();
    check("R5 cleared", pend_word, 32'h0);

    // R6: bus error clears
    hw_req_en = 16'h0200; hw_req = 16'h0200; step("R6 set"); idle();
    bus_fault = 1; bus_fault_ch = 9; step("R6 bus error"); idle();
    check("R6 cleared", pend_word, 32'h0);

    // R8 / R9: queue entry survives global disable and emulation
    q_enter = 1; q_enter_ch = 2; step("R8 enter"); idle();
    dma_global_en = 0; emu_active = 1; step("R9 modes changed");
    check("R9 active persists", active_word, 32'h0000_0004);
    dma_global_en = 1; emu_active = 0;
    q_enter = 1; q_enter_ch = 2; q_leave = 1; q_leave_ch = 2;
    step("R8 enter and leave same cycle"); idle();
    check("R8 leave wins", active_word, 32'h0);

    // Random traffic; R1 upper half checked in every compare
    for (int k = 0; k < 4000; k++) begin
      hw_req = 16'($urandom) & 16'($urandom);
      sw_req = 16'($urandom) & 16'($urandom);
      if (k % 64 == 0) begin
        hw_req_en = 16'($urandom); sw_req_en = 16'($urandom); xfer_is_block = 16'($urandom);
      end
      frame_end = $urandom_range(0, 3) == 0; frame_end_ch = 4'($urandom);
      block_end = $urandom_range(0, 3) == 0; block_end_ch = 4'($urandom);
      pkt_write = $urandom_range(0, 5) == 0; pkt_write_ch = 4'($urandom);
      bus_fault = $urandom_range(0, 7) == 0; bus_fault_ch = 4'($urandom);
      q_enter = $urandom_range(0, 1) == 0; q_enter_ch = 4'($urandom);
      q_leave = $urandom_range(0, 2) == 0; q_leave_ch = 4'($urandom);
      dma_global_en = 1'($urandom); emu_active = 1'($urandom);
      step("R1/R2/R4/R5/R6/R7/R8 random");
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule